// File: doc/BRIEF.md
# Prescaled Machine Timer with Compare

The block is a single-hart machine timer that software reaches through a small register port. It holds a 64-bit time count. A 12-bit prescaler counter runs while the timer is enabled and produces a one-cycle tick each time it reaches the programmed prescale value. On each tick, an 8-bit programmable step is added to the time count. Both the time count and a 64-bit compare value are reached as two 32-bit halves.

Each cycle, the block registers whether the time count is greater than or equal to the compare value into a level-type interrupt status bit. The interrupt line is that status gated by an enable bit. Software may rewrite any setting while the timer runs. The compare decision always uses the values currently held, so moving the compare value upward before it is reached keeps the interrupt quiet. A test register forces the status bit high for one cycle, so that the interrupt path can be exercised without waiting for the count.

Accesses use a request strobe with a write enable. A read returns its data one cycle after the request, flagged by a read-valid strobe.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the registers hold these values: enable 0, prescale 0, step 1, time count 0, compare all ones, interrupt enable 0, status 0. A read of the test register returns 0.
- R2: While the enable bit is 0, the time count holds its value, the prescaler counter stays at zero and the status bit reads 0, whatever the compare and interrupt-enable registers contain. Only a write to the test register overrides this.
- R3: While the timer is enabled with prescale value P, ticks occur once every P+1 cycles. The first tick occurs P+1 cycles after the enable bit takes effect. When P is 0, a tick occurs in every cycle. No tick occurs without the enable bit, and the time count changes only on a tick or on a software write.
- R4: Each tick adds the step to the time count, modulo 2^64. A step of 0 leaves the count unchanged while ticks continue.
- R5: One cycle after any cycle in which the timer is enabled and time >= compare, the status bit is 1. The condition includes equality. It also includes a compare value written at or below the current count, which needs no further tick. One cycle after the condition is false, the status bit is 0.
- R6: The interrupt output is the status bit ANDed with interrupt-enable bit 0. With the enable bit cleared, the status can read 1 while the output stays 0.
- R7: Writes to the status register are ignored. Writing 1 in bit 0 of the test register sets the status bit for the next cycle only. Writing 0 there has no effect.
- R8: Register map, by address: 0 enable (bit 0), 1 configuration, 2 time low, 3 time high, 4 compare low, 5 compare high, 6 interrupt enable (bit 0), 7 status (bit 0), 8 test (bit 0). In the configuration register, the prescale value is in bits 11:0 and the step is in bits 23:16. All other bits read 0.
- R9: Changes to the compare value while the timer is running take effect in the next cycle. Raising the compare value before the count reaches it prevents the interrupt. A write to either time half in a cycle that also has a tick takes the written value, and that cycle adds no step.
- R10: An asynchronous reset asserted while the timer is running drops the interrupt at once and returns every register to its R1 value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | High one cycle after a read request |
| intr_o | output | 1 | Timer interrupt |

## Verification
A software write to a time half and a prescaler tick can land in the same cycle. The bench forces this collision by setting the prescale value to 0, so that every enabled cycle ticks, and then writing the low half of the time count while the timer runs. The enable bit is cleared on the very next edge, and that edge adds exactly one step. A read-back of exactly the written value plus one step shows that the write won its own cycle and that counting then resumed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned STEP_LSB = 16;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 4'd0,
        A_CFG   = 4'd1,
        A_TLO   = 4'd2,
        A_THI   = 4'd3,
        A_CLO   = 4'd4,
        A_CHI   = 4'd5,
        A_IEN   = 4'd6,
        A_IST   = 4'd7,
        A_ITEST = 4'd8
    } reg_addr_e;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned PW = 12,
    parameter int unsigned SW = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DW-1:0]       wdata_i,
    input  logic [2*DW-1:0]     time_i,
    input  logic                istate_i,
    output logic [DW-1:0]       rdata_o,
    output logic                rvalid_o,
    output logic                active_o,
    output logic [PW-1:0]       presc_o,
    output logic [SW-1:0]       step_o,
    output logic [2*DW-1:0]     cmp_o,
    output logic                ien_o,
    output logic                wr_tlo_o,
    output logic                wr_thi_o,
    output logic                test_o
);

    localparam int unsigned TW = 2 * DW;

    typedef struct packed {
        logic          active;
        logic [PW-1:0] presc;
        logic [SW-1:0] step;
        logic [TW-1:0] cmp;
        logic          ien;
        logic [DW-1:0] rdata;
        logic          rvalid;
    } regs_t;

    regs_t s_d, s_q;
    logic  wr, rd;
    logic [DW-1:0] rmux;

    assign wr = req_i && we_i;
    assign rd = req_i && !we_i;

    always_comb begin
        rmux = '0;
        case (addr_i)
            A_CTRL: rmux[0] = s_q.active;
            A_CFG: begin
                rmux[PW-1:0]          = s_q.presc;
                rmux[STEP_LSB +: SW]  = s_q.step;
            end
            A_TLO:  rmux = time_i[DW-1:0];
            A_THI:  rmux = time_i[TW-1:DW];
            A_CLO:  rmux = s_q.cmp[DW-1:0];
            A_CHI:  rmux = s_q.cmp[TW-1:DW];
            A_IEN:  rmux[0] = s_q.ien;
            A_IST:  rmux[0] = istate_i;
            default: rmux = '0;
        endcase
    end

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = rd;
        wr_tlo_o   = wr && (addr_i == A_TLO);
        wr_thi_o   = wr && (addr_i == A_THI);
        test_o     = wr && (addr_i == A_ITEST) && wdata_i[0];
        if (wr) begin
            case (addr_i)
                A_CTRL: s_d.active = wdata_i[0];
                A_CFG: begin
                    s_d.presc = wdata_i[PW-1:0];
                    s_d.step  = wdata_i[STEP_LSB +: SW];
                end
                A_CLO:  s_d.cmp[DW-1:0]  = wdata_i;
                A_CHI:  s_d.cmp[TW-1:DW] = wdata_i;
                A_IEN:  s_d.ien = wdata_i[0];
                default: ;
            endcase
        end
        if (rd) begin
            s_d.rdata = rmux;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q      <= '0;
            s_q.step <= SW'(1);
            s_q.cmp  <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o  = s_q.rdata;
    assign rvalid_o = s_q.rvalid;
    assign active_o = s_q.active;
    assign presc_o  = s_q.presc;
    assign step_o   = s_q.step;
    assign cmp_o    = s_q.cmp;
    assign ien_o    = s_q.ien;

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned PW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          active_i,
    input  logic [PW-1:0] presc_i,
    output logic          tick_o
);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } psc_t;

    psc_t p_d, p_q;

    always_comb begin
        p_d    = p_q;
        tick_o = active_i && (p_q.cnt == presc_i);
        if (!active_i || tick_o) begin
            p_d.cnt = '0;
        end else begin
            p_d.cnt = p_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int unsigned DW = 32,
    parameter int unsigned SW = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [SW-1:0]     step_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [2*DW-1:0]   time_o
);

    localparam int unsigned TW = 2 * DW;

    typedef struct packed {
        logic [TW-1:0] val;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr_lo_i || wr_hi_i) begin
            if (wr_lo_i) c_d.val[DW-1:0]  = wdata_i;
            if (wr_hi_i) c_d.val[TW-1:DW] = wdata_i;
        end else if (tick_i) begin
            c_d.val = c_q.val + TW'(step_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign time_o = c_q.val;

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
    parameter int unsigned TW = 64
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          active_i,
    input  logic [TW-1:0] time_i,
    input  logic [TW-1:0] cmp_i,
    input  logic          test_i,
    input  logic          ien_i,
    output logic          istate_o,
    output logic          intr_o
);

    typedef struct packed {
        logic istate;
    } irq_t;

    irq_t i_d, i_q;
    logic hit;

    always_comb begin
        i_d        = i_q;
        hit        = active_i && (time_i >= cmp_i);
        i_d.istate = hit || test_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            i_q <= '0;
        end else begin
            i_q <= i_d;
        end
    end

    assign istate_o = i_q.istate;
    assign intr_o   = i_q.istate && ien_i;

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import tmr_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned PW = 12,
    parameter int unsigned SW = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              rvalid_o,
    output logic              intr_o
);

    localparam int unsigned TW = 2 * DW;

    logic          active;
    logic [PW-1:0] presc;
    logic [SW-1:0] step;
    logic [TW-1:0] cmp;
    logic [TW-1:0] cnt_time;
    logic          ien, istate, tick;
    logic          wr_tlo, wr_thi, test;

    tmr_regs #(.DW(DW), .PW(PW), .SW(SW)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (req_i),
        .we_i     (we_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .time_i   (cnt_time),
        .istate_i (istate),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o),
        .active_o (active),
        .presc_o  (presc),
        .step_o   (step),
        .cmp_o    (cmp),
        .ien_o    (ien),
        .wr_tlo_o (wr_tlo),
        .wr_thi_o (wr_thi),
        .test_o   (test)
    );

    tmr_prescale #(.PW(PW)) u_psc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (active),
        .presc_i  (presc),
        .tick_o   (tick)
    );

    tmr_count #(.DW(DW), .SW(SW)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .step_i  (step),
        .wr_lo_i (wr_tlo),
        .wr_hi_i (wr_thi),
        .wdata_i (wdata_i),
        .time_o  (cnt_time)
    );

    tmr_irq #(.TW(TW)) u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (active),
        .time_i   (cnt_time),
        .cmp_i    (cmp),
        .test_i   (test),
        .ien_i    (ien),
        .istate_o (istate),
        .intr_o   (intr_o)
    );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int unsigned TW = 64,
    parameter int unsigned PW = 12,
    parameter int unsigned SW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          req_i,
    input logic          we_i,
    input logic [3:0]    addr_i,
    input logic          wbit0_i,
    input logic          active_i,
    input logic          tick_i,
    input logic [PW-1:0] presc_i,
    input logic [SW-1:0] step_i,
    input logic [TW-1:0] time_i,
    input logic [TW-1:0] cmp_i,
    input logic          istate_i
);

    logic twr, testw, cfgw, hit;
    assign twr   = req_i && we_i && (addr_i == 4'd2 || addr_i == 4'd3);
    assign testw = req_i && we_i && (addr_i == 4'd8) && wbit0_i;
    assign cfgw  = req_i && we_i && (addr_i == 4'd1);
    assign hit   = active_i && (time_i >= cmp_i);

    assert_hold_inactive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!active_i && !twr) |=> $stable(time_i));

    assert_quiet_inactive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!active_i && !testw) |=> !istate_i);

    assert_no_tick_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !twr) |=> $stable(time_i));

    assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && presc_i != '0 && !cfgw) |=> !tick_i);

    assert_step_add_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !twr) |=> (time_i == $past(time_i) + TW'($past(step_i))));

    assert_ge_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |=> istate_i);

    assert_lt_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hit && !testw) |=> !istate_i);

    assert_test_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        testw |=> istate_i);

endmodule

bind prescaled_timer tmr_checker #(.TW(TW), .PW(PW), .SW(SW)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wbit0_i  (wdata_i[0]),
    .active_i (active),
    .tick_i   (tick),
    .presc_i  (presc),
    .step_i   (step),
    .time_i   (cnt_time),
    .cmp_i    (cmp),
    .istate_i (istate)
);

// File: tb/test_prescaled_timer.sv
`timescale 1ns/1ps
module test_prescaled_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic        intr;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [31:0] exp;
        logic [3:0]  a;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    prescaled_timer i_prescaled_timer (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .req_i    (req),
        .we_i     (we),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .rvalid_o (rvalid),
        .intr_o   (intr)
    );

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.a = a; it.tag = tag;
        sb.push_back(it);
        req = 1'b1; we = 1'b0; addr = a;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        vectors++;
        if (intr !== e) begin
            errors++;
            $display("FAIL %s: intr_o got %0b expected %0b", tag, intr, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            vectors++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: unexpected read data %08h expected none", rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: addr %0d got %08h expected %08h", it.tag, it.a, rdata, it.exp);
                end
            end
        end
    end

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        chk_irq(1'b0, "R1 intr after reset");
        rd(4'd0, 32'h0,        "R1 ctrl");
        rd(4'd1, 32'h00010000, "R1 cfg");
        rd(4'd2, 32'h0,        "R1 time lo");
        rd(4'd3, 32'h0,        "R1 time hi");
        rd(4'd4, 32'hFFFFFFFF, "R1 cmp lo");
        rd(4'd5, 32'hFFFFFFFF, "R1 cmp hi");
        rd(4'd6, 32'h0,        "R1 ien");
        rd(4'd7, 32'h0,        "R1 status");
        rd(4'd8, 32'h0,        "R1 test reads 0");

        // R2: inactive timer stays quiet with compare 0 and enable 1
        wr(4'd4, 32'h0); wr(4'd5, 32'h0); wr(4'd6, 32'h1);
        wr(4'd1, 32'h00050000);
        repeat (20) @(negedge clk);
        chk_irq(1'b0, "R2 no intr while inactive");
        rd(4'd2, 32'h0, "R2 time held lo");
        rd(4'd7, 32'h0, "R2 status 0 while inactive");

        // R8: field layout and unused bits
        wr(4'd1, 32'hFFFFFFFF);
        rd(4'd1, 32'h00FF0FFF, "R8 cfg fields only");

        // R3/R4: prescale 3, step 5, 21 enabled edges -> 5 ticks
        wr(4'd4, 32'hFFFFFFFF); wr(4'd5, 32'hFFFFFFFF);
        wr(4'd1, 32'h00050003);
        rd(4'd1, 32'h00050003, "R8 cfg readback");
        wr(4'd0, 32'h1);
        repeat (20) @(negedge clk);
        wr(4'd0, 32'h0);
        rd(4'd2, 32'd25, "R3 prescaled tick count");
        rd(4'd3, 32'h0,  "R3 time hi");

        // R4: step 0 with prescale 0 keeps the count
        wr(4'd1, 32'h0);
        wr(4'd2, 32'd100);
        wr(4'd0, 32'h1);
        repeat (10) @(negedge clk);
        wr(4'd0, 32'h0);
        rd(4'd2, 32'd100, "R4 step 0 holds");

        // R4: wrap modulo 2^64
        wr(4'd3, 32'hFFFFFFFF); wr(4'd2, 32'hFFFFFFFE);
        wr(4'd1, 32'h00030000);
        wr(4'd0, 32'h1);
        wr(4'd0, 32'h0);
        rd(4'd2, 32'h1, "R4 wrap lo");
        rd(4'd3, 32'h0, "R4 wrap hi");

        // R5: compare below count fires without counting
        wr(4'd1, 32'h0);
        wr(4'd3, 32'h0); wr(4'd2, 32'd50);
        wr(4'd4, 32'd40); wr(4'd5, 32'h0);
        chk_irq(1'b0, "R2 inactive with compare below");
        wr(4'd0, 32'h1);
        chk_irq(1'b0, "R5 one cycle latency");
        @(negedge clk);
        chk_irq(1'b1, "R5 compare below count");
        wr(4'd4, 32'd50);
        @(negedge clk);
        chk_irq(1'b1, "R5 equality");
        wr(4'd4, 32'd51);
        @(negedge clk);
        chk_irq(1'b0, "R5 compare above clears");
        wr(4'd4, 32'd50);
        @(negedge clk);
        rd(4'd7, 32'h1, "R5 status set");

        // R6: enable gating
        wr(4'd6, 32'h0);
        chk_irq(1'b0, "R6 enable off");
        rd(4'd7, 32'h1, "R6 status still 1");

        // R7: status write ignored
        wr(4'd7, 32'h0);
        rd(4'd7, 32'h1, "R7 status write ignored");
        wr(4'd6, 32'h1);
        wr(4'd0, 32'h0);
        @(negedge clk);
        rd(4'd7, 32'h0, "R2 status drops when inactive");
        wr(4'd7, 32'h1);
        rd(4'd7, 32'h0, "R7 status write 1 ignored");

        // R7: test pulse
        wr(4'd8, 32'h1);
        chk_irq(1'b1, "R7 test pulse set");
        @(negedge clk);
        chk_irq(1'b0, "R7 test pulse one cycle");
        wr(4'd8, 32'h0);
        chk_irq(1'b0, "R7 test write 0 no effect");

        // R9: raising compare before expiry
        wr(4'd1, 32'h00010000);
        wr(4'd3, 32'h0); wr(4'd2, 32'h0);
        wr(4'd4, 32'd6); wr(4'd5, 32'h0);
        wr(4'd0, 32'h1);
        repeat (2) @(negedge clk);
        wr(4'd4, 32'd1000);
        repeat (10) @(negedge clk);
        chk_irq(1'b0, "R9 raised compare suppresses");
        rd(4'd7, 32'h0, "R9 status stays 0");

        // R9: write collides with tick
        wr(4'd2, 32'd500);
        wr(4'd0, 32'h0);
        rd(4'd2, 32'd501, "R9 write wins over tick");
        rd(4'd3, 32'h0,   "R9 time hi");

        // R10: asynchronous reset mid-run
        wr(4'd4, 32'h0);
        wr(4'd0, 32'h1);
        @(negedge clk);
        chk_irq(1'b1, "R10 intr before reset");
        #1 rst_n = 1'b0;
        #1 chk_irq(1'b0, "R10 intr cleared by reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'd0, 32'h0,        "R10 ctrl");
        rd(4'd1, 32'h00010000, "R10 cfg");
        rd(4'd2, 32'h0,        "R10 time lo");
        rd(4'd5, 32'hFFFFFFFF, "R10 cmp hi");
        rd(4'd6, 32'h0,        "R10 ien");
        rd(4'd7, 32'h0,        "R10 status");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d reads outstanding expected 0", sb.size());
        end
        finish_run();
    end

endmodule